// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block carries out a full hardware context switch between tasks. A request names a far JMP, a far CALL or an IRET together with a selector. The selector is resolved through a small descriptor table that is written over a configuration port. A descriptor may be a state segment descriptor or a gate that names another selector. All validity checks run before any state is touched. The block then stores the outgoing task's dynamic registers into that task's state segment through a word-wide memory port. It reads the incoming segment back, hands every loaded word to the register file, and finally replaces the task register.

Each state segment is a run of 32-bit words at the descriptor's base address. The word offsets are:

| Offset | Content |
|---|---|
| 0 | back-link selector |
| 1 to 6 | stack pointers |
| 7 | page directory base |
| 8 | instruction pointer |
| 9 | flags |
| 10 to 17 | general registers |
| 18 to 23 | segment registers |
| 24 | local table selector |
| 25 | trap bit in bit 0, I/O map base in bits 31:16 |

The register file is addressed with the same word offsets. A CALL chains the new task back to the caller through the link word and the nested flag (flags bit 14). IRET follows that chain back.

Top module: `task_switch_seq`

## Requirements
- R1: A JMP to a present state segment descriptor (kind 1) with a limit of at least 26 words does the following, in order. It writes register-file words 8 to 23 to offsets 8 to 23 of the current segment, in ascending order. It reads offsets 1 to 25 of the new segment, in ascending order, and writes each word to the register file at the same index. It then sets the task register to the requested selector and raises done.
- R2: A gate descriptor (kind 2) is replaced by the selector it holds, and that selector is looked up once more. A gate that leads to a second gate is a type fault (code 1).
- R3: A CALL does two things after the save and before the load: it writes the old task register value, zero-extended, to offset 0 of the new segment, and it sets bit 14 of the loaded flags word (offset 9).
- R4: A JMP never writes offset 0 of the new segment, and it loads the flags word unmodified.
- R5: An IRET when bit 14 of register-file word 9 is set reads offset 0 of the current segment. It switches to the selector found there, saving as in R1, and it does no link write.
- R6: An IRET when bit 14 of register-file word 9 is clear raises fault code 3. It makes no memory access and no register-file write.
- R7: Faults are code 0 for a descriptor that is not present, code 1 for a descriptor of kind 0 or 3, and code 2 for a segment limit below 26 words. A fault causes no memory write and no register-file write, and it leaves the task register unchanged.
- R8: Offsets 1 to 7, 24 and 25 of any segment are never written.
- R9: done is a one-cycle pulse. In that same cycle the trap output equals bit 0 of the new segment's offset 25 word.
- R10: Once the memory request is raised, the request, write enable, address and write data stay stable until the cycle in which ready is high.
- R11: A request is taken only while req_ready is high. A request presented while a switch is running has no effect.

Request kinds are 0 for JMP, 1 for CALL and 2 for IRET. A selector's table index is taken from bits IDX_W+2 down to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Switch request strobe |
| req_kind | input | 2 | 0 JMP, 1 CALL, 2 IRET |
| req_sel | input | 16 | Target selector (unused for IRET) |
| req_ready | output | 1 | Idle, request accepted |
| done | output | 1 | Switch completed pulse |
| fault | output | 1 | Switch refused pulse |
| fault_code | output | 2 | Cause of the last fault |
| tr_sel | output | 16 | Task register |
| tbit | output | 1 | Trap bit of the task last loaded |
| cfg_we | input | 1 | Descriptor table write |
| cfg_idx | input | IDX_W | Table slot |
| cfg_present | input | 1 | Present bit |
| cfg_kind | input | 2 | 0 none, 1 segment, 2 gate, 3 reserved |
| cfg_base | input | 32 | Segment base word address |
| cfg_limit | input | 16 | Segment size in words |
| cfg_gate_sel | input | 16 | Selector held by a gate |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ready |
| mem_rdy | input | 1 | Access completes this cycle |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |

## Verification
The bench builds the block with IDX_W = 3 and TR_RST = 16'h0008. With eight table slots, every descriptor class can be present at once: three valid segments, a gate, a gate that leads to a gate, a non-present entry, a reserved kind, and a segment one word short of the minimum. A single run therefore covers the chain JMP, then CALL through a gate, then IRET back, then a refused IRET, as well as the limit boundary between 25 and 26 words. Memory ready is driven from a pseudo-random sequence, so that wait states land at every step of the save and load streams.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int OFF_W  = 5;

  localparam logic [OFF_W-1:0] OFF_LINK  = 5'd0;
  localparam logic [OFF_W-1:0] OFF_LOAD0 = 5'd1;
  localparam logic [OFF_W-1:0] OFF_DYN0  = 5'd8;
  localparam logic [OFF_W-1:0] OFF_FLAGS = 5'd9;
  localparam logic [OFF_W-1:0] OFF_DYN1  = 5'd23;
  localparam logic [OFF_W-1:0] OFF_TRAP  = 5'd25;
  localparam logic [15:0]      MIN_LIMIT = 16'd26;
  localparam int               NEST_BIT  = 14;

  typedef enum logic [1:0] {REQ_JMP = 2'd0, REQ_CALL = 2'd1, REQ_IRET = 2'd2} req_kind_e;
  typedef enum logic [1:0] {DK_NONE = 2'd0, DK_SEG = 2'd1, DK_GATE = 2'd2, DK_RSV = 2'd3} desc_kind_e;
  typedef enum logic [1:0] {FLT_NP = 2'd0, FLT_TYPE = 2'd1, FLT_LIMIT = 2'd2, FLT_NEST = 2'd3} fault_e;
  typedef enum logic [2:0] {S_IDLE, S_LINKRD, S_LOOK, S_SAVE, S_LINKWR, S_LOAD} seq_e;

  typedef struct packed {
    logic              present;
    desc_kind_e        kind;
    logic [WORD_W-1:0] base;
    logic [15:0]       limit;
    logic [SEL_W-1:0]  gate_sel;
  } desc_t;

  // address of a segment word
  function automatic logic [WORD_W-1:0] seg_word(input logic [WORD_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    return base + {{(WORD_W-OFF_W){1'b0}}, off};
  endfunction

  // flags word as loaded; a CALL marks the new task as nested
  function automatic logic [WORD_W-1:0] load_flags(input logic [WORD_W-1:0] w,
                                                    input logic nest);
    return nest ? (w | (32'd1 << NEST_BIT)) : w;
  endfunction
endpackage

// File: rtl/tss_desc_table.sv
module tss_desc_table
  import tss_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  desc_t             cfg_desc,
  input  logic [IDX_W-1:0]  a_idx,
  output desc_t             a_desc,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [WORD_W-1:0] b_base
);
  localparam int N = 1 << IDX_W;

  desc_t tbl [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      tbl[cfg_idx] <= cfg_desc;
    end
  end

  assign a_desc = tbl[a_idx];
  assign b_base = tbl[b_idx].base;
endmodule

// File: rtl/tss_desc_check.sv
module tss_desc_check
  import tss_pkg::*;
(
  input  desc_t  d,
  input  logic   via_gate,
  output logic   seg_ok,
  output logic   follow,
  output logic   flt,
  output fault_e code
);
  always_comb begin
    seg_ok = 1'b0;
    follow = 1'b0;
    flt    = 1'b0;
    code   = FLT_NP;
    if (!d.present) begin
      flt = 1'b1;
    end else begin
      case (d.kind)
        DK_SEG: begin
          if (d.limit < MIN_LIMIT) begin flt = 1'b1; code = FLT_LIMIT; end
          else seg_ok = 1'b1;
        end
        DK_GATE: begin
          if (via_gate) begin flt = 1'b1; code = FLT_TYPE; end
          else follow = 1'b1;
        end
        default: begin flt = 1'b1; code = FLT_TYPE; end
      endcase
    end
  end
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tss_pkg::*;
#(
  parameter int          IDX_W  = 3,
  parameter logic [15:0] TR_RST = 16'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [15:0]      req_sel,
  output logic             req_ready,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_code,
  output logic [15:0]      tr_sel,
  output logic             tbit,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_present,
  input  logic [1:0]       cfg_kind,
  input  logic [31:0]      cfg_base,
  input  logic [15:0]      cfg_limit,
  input  logic [15:0]      cfg_gate_sel,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rdy,
  output logic [4:0]       rf_rd_idx,
  input  logic [31:0]      rf_rd_data,
  output logic             rf_wr_en,
  output logic [4:0]       rf_wr_idx,
  output logic [31:0]      rf_wr_data
);
  localparam int IHI = IDX_W + 2;

  seq_e             state;
  req_kind_e        kind_q;
  logic [SEL_W-1:0] tgt_q, tr_q;
  logic             via_gate_q, checked_q, done_q, fault_q, tbit_q;
  fault_e           code_q;
  logic [OFF_W-1:0] off_q;
  logic [31:0]      new_base_q, cur_base;
  desc_t            cfg_desc, a_desc;
  logic             a_ok, a_follow, a_flt;
  fault_e           a_code;

  assign cfg_desc = '{present: cfg_present, kind: desc_kind_e'(cfg_kind), base: cfg_base,
                      limit: cfg_limit, gate_sel: cfg_gate_sel};

  tss_desc_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_desc(cfg_desc),
    .a_idx(tgt_q[IHI:3]), .a_desc(a_desc), .b_idx(tr_q[IHI:3]), .b_base(cur_base)
  );

  tss_desc_check u_chk (
    .d(a_desc), .via_gate(via_gate_q), .seg_ok(a_ok), .follow(a_follow),
    .flt(a_flt), .code(a_code)
  );

  // named events for the assertions
  wire xfer_done = mem_req && mem_rdy;
  wire wr_xfer   = xfer_done && mem_we;
  wire last_load = (state == S_LOAD) && mem_rdy && (off_q == OFF_TRAP);
  wire [31:0] save_off = mem_addr - cur_base;

  always_comb begin
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    rf_rd_idx  = OFF_FLAGS;
    rf_wr_en   = 1'b0;
    rf_wr_idx  = off_q;
    rf_wr_data = (off_q == OFF_FLAGS) ? load_flags(mem_rdata, kind_q == REQ_CALL) : mem_rdata;
    case (state)
      S_LINKRD: begin mem_req = 1'b1; mem_addr = seg_word(cur_base, OFF_LINK); end
      S_SAVE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = seg_word(cur_base, off_q);
        rf_rd_idx = off_q;
        mem_wdata = rf_rd_data;
      end
      S_LINKWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = seg_word(new_base_q, OFF_LINK);
        mem_wdata = {16'd0, tr_q};
      end
      S_LOAD: begin
        mem_req  = 1'b1;
        mem_addr = seg_word(new_base_q, off_q);
        rf_wr_en = mem_rdy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind_q     <= REQ_JMP;
      tgt_q      <= '0;
      tr_q       <= TR_RST;
      via_gate_q <= 1'b0;
      checked_q  <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      tbit_q     <= 1'b0;
      code_q     <= FLT_NP;
      off_q      <= '0;
      new_base_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          kind_q     <= req_kind_e'(req_kind);
          via_gate_q <= 1'b0;
          checked_q  <= 1'b0;
          if (req_kind == REQ_IRET) begin
            if (!rf_rd_data[NEST_BIT]) begin fault_q <= 1'b1; code_q <= FLT_NEST; end
            else state <= S_LINKRD;
          end else begin
            tgt_q <= req_sel;
            state <= S_LOOK;
          end
        end
        S_LINKRD: if (mem_rdy) begin
          tgt_q <= mem_rdata[SEL_W-1:0];
          state <= S_LOOK;
        end
        S_LOOK: begin
          if (a_flt) begin
            fault_q <= 1'b1;
            code_q  <= a_code;
            state   <= S_IDLE;
          end else if (a_follow) begin
            tgt_q      <= a_desc.gate_sel;
            via_gate_q <= 1'b1;
          end else if (a_ok) begin
            new_base_q <= a_desc.base;
            checked_q  <= 1'b1;
            off_q      <= OFF_DYN0;
            state      <= S_SAVE;
          end
        end
        S_SAVE: if (mem_rdy) begin
          if (off_q == OFF_DYN1) begin
            off_q <= OFF_LOAD0;
            state <= (kind_q == REQ_CALL) ? S_LINKWR : S_LOAD;
          end else begin
            off_q <= off_q + 5'd1;
          end
        end
        S_LINKWR: if (mem_rdy) state <= S_LOAD;
        S_LOAD: if (mem_rdy) begin
          if (off_q == OFF_TRAP) begin
            tbit_q    <= mem_rdata[0];
            tr_q      <= tgt_q;
            done_q    <= 1'b1;
            checked_q <= 1'b0;
            state     <= S_IDLE;
          end else begin
            off_q <= off_q + 5'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign tr_sel     = tr_q;
  assign tbit       = tbit_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_TR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tr_q) |-> done_q); // R1
  AST_FAULT_KEEP_TR: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $stable(tr_q)); // R7
  AST_WRITE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xfer || rf_wr_en) |-> checked_q); // R7
  AST_STATIC_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && state == S_SAVE |-> save_off >= 32'd8 && save_off <= 32'd23); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, fault_q})); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_load |=> done_q ##1 !done_q); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(kind_q)); // R11
endmodule

// File: tb/task_switch_seq_tb.sv
module task_switch_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, done, fault, tbit;
  logic [1:0]  req_kind, fault_code;
  logic [15:0] req_sel, tr_sel;
  logic        cfg_we, cfg_present;
  logic [2:0]  cfg_idx;
  logic [1:0]  cfg_kind;
  logic [31:0] cfg_base;
  logic [15:0] cfg_limit, cfg_gate_sel;
  logic        mem_req, mem_we, mem_rdy, rf_wr_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [4:0]  rf_rd_idx, rf_wr_idx;

  logic [31:0] mem [256];
  logic [31:0] rf  [32];
  logic [63:0] exp_q [$];
  int n_chk = 0, n_fail = 0, n_xfer = 0;
  logic [7:0] lfsr = 8'h5a;

  assign mem_rdata  = mem[mem_addr[7:0]];
  assign rf_rd_data = rf[rf_rd_idx];

  task_switch_seq #(.IDX_W(3), .TR_RST(16'h0008)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_sel(req_sel),
    .req_ready(req_ready), .done(done), .fault(fault), .fault_code(fault_code),
    .tr_sel(tr_sel), .tbit(tbit), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_present(cfg_present), .cfg_kind(cfg_kind), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_gate_sel(cfg_gate_sel), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: memory and register-file models, scoreboard of memory writes
  initial begin
    mem_rdy = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req && mem_rdy) n_xfer++;
      if (mem_req && mem_we && mem_rdy) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected memory write", mem_addr, 32'h0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(mem_addr == e[63:32], "R10", "write address order", mem_addr, e[63:32]);
          check(mem_wdata == e[31:0], "R10", "write data", mem_wdata, e[31:0]);
        end
        mem[mem_addr[7:0]] = mem_wdata;
      end
      if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rdy = lfsr[0] | lfsr[1];
    end
  end

  task automatic put_desc(input logic [2:0] idx, input logic p, input logic [1:0] k,
                          input logic [31:0] b, input logic [15:0] lim, input logic [15:0] g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_present = p; cfg_kind = k;
    cfg_base = b; cfg_limit = lim; cfg_gate_sel = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [15:0] s);
    @(negedge clk);
    for (int t = 0; t < 100 && !req_ready; t++) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int t = 0; t < 2000 && !(done || fault); t++) @(negedge clk);
  endtask

  // kind: 0 JMP, 1 CALL, 2 IRET
  task automatic run_switch(input logic [1:0] k, input logic [15:0] s, input logic [31:0] cur_b,
                            input logic [31:0] new_b, input logic [15:0] new_tr,
                            input bit inject, input string tag);
    logic [31:0] exp_rf [32];
    logic [31:0] stat_snap [32];
    logic [31:0] link_before;
    logic [15:0] tr_old;
    int bad;
    tr_old = tr_sel;
    link_before = mem[new_b[7:0]];
    for (int i = 8; i <= 23; i++) exp_q.push_back({cur_b + i, rf[i]});
    if (k == 2'd1) exp_q.push_back({new_b, 16'h0000, tr_old});
    for (int i = 0; i < 32; i++) begin
      exp_rf[i] = rf[i];
      stat_snap[i] = mem[(cur_b[7:0] + i[7:0])];
    end
    for (int i = 1; i <= 25; i++) exp_rf[i] = mem[new_b[7:0] + i[7:0]];
    if (k == 2'd1) exp_rf[9] = exp_rf[9] | 32'h0000_4000;
    issue(k, s);
    if (inject) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd0; req_sel = 16'h0028;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_end();
    check(done && !fault, tag, "done without fault", {30'd0, done, fault}, 32'h2);
    check(tr_sel == new_tr, "R1", "task register", {16'd0, tr_sel}, {16'd0, new_tr});
    check(tbit == exp_rf[25][0], "R9", "trap bit at done", {31'd0, tbit}, {31'd0, exp_rf[25][0]});
    check(exp_q.size() == 0, tag, "pending expected writes", exp_q.size(), 0);
    bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) bad++;
    check(bad == 0, "R1", "register file load mismatches", bad, 0);
    bad = 0;
    for (int i = 1; i <= 25; i++)
      if ((i < 8 || i > 23) && mem[cur_b[7:0] + i[7:0]] !== stat_snap[i]) bad++;
    check(bad == 0, "R8", "static words changed", bad, 0);
    if (k == 2'd1) check(rf[9][14], "R3", "nested flag after CALL", rf[9], exp_rf[9]);
    if (k == 2'd0) begin
      check(mem[new_b[7:0]] == link_before, "R4", "link untouched by JMP",
            mem[new_b[7:0]], link_before);
      check(!rf[9][14], "R4", "flags unmodified by JMP", rf[9], exp_rf[9]);
    end
    @(negedge clk);
    check(!done, "R9", "done lasts one cycle", {31'd0, done}, 32'd0);
    if (inject) begin
      bad = 0;
      for (int t = 0; t < 12; t++) begin
        if (fault || !req_ready || mem_req) bad++;
        @(negedge clk);
      end
      check(bad == 0 && tr_sel == new_tr, "R11", "request while busy ignored", bad, 0);
    end
  endtask

  task automatic run_fault(input logic [1:0] k, input logic [15:0] s,
                           input logic [1:0] code, input string tag);
    logic [31:0] snap [32];
    logic [15:0] tr_old;
    int bad, x0;
    tr_old = tr_sel;
    x0 = n_xfer;
    for (int i = 0; i < 32; i++) snap[i] = rf[i];
    issue(k, s);
    wait_end();
    check(fault && !done, tag, "fault raised", {30'd0, fault, done}, 32'h2);
    check(fault_code == code, tag, "fault code", {30'd0, fault_code}, {30'd0, code});
    check(tr_sel == tr_old, "R7", "task register kept", {16'd0, tr_sel}, {16'd0, tr_old});
    bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== snap[i]) bad++;
    check(bad == 0, tag, "register file unchanged", bad, 0);
    if (code == 2'd3) check(n_xfer == x0, "R6", "no memory access", n_xfer - x0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_sel = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_present = 1'b0; cfg_kind = '0;
    cfg_base = '0; cfg_limit = '0; cfg_gate_sel = '0;
    for (int i = 0; i < 256; i++) mem[i] = (32'h3C00_0000 + i * 32'h0001_0203) & ~32'h0000_4000;
    for (int i = 0; i < 32; i++) rf[i] = (32'h7700_0000 | (i * 32'h0000_0101)) & ~32'h0000_4000;
    mem[8'h20 + 25] = mem[8'h20 + 25] | 32'h1;
    mem[8'h40 + 25] = mem[8'h40 + 25] & ~32'h1;
    mem[8'h60 + 25] = mem[8'h60 + 25] | 32'h1;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !fault && !mem_req, "R11", "idle during reset",
          {28'd0, req_ready, done, fault, mem_req}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(tr_sel == 16'h0008, "R1", "task register after reset", {16'd0, tr_sel}, 32'h8);
    put_desc(3'd0, 1'b1, 2'd2, 32'h0,  16'd0,  16'h0018);
    put_desc(3'd1, 1'b1, 2'd1, 32'h20, 16'd26, 16'h0);
    put_desc(3'd2, 1'b1, 2'd1, 32'h40, 16'd30, 16'h0);
    put_desc(3'd3, 1'b1, 2'd2, 32'h0,  16'd0,  16'h0020);
    put_desc(3'd4, 1'b1, 2'd1, 32'h60, 16'd26, 16'h0);
    put_desc(3'd5, 1'b0, 2'd1, 32'hA0, 16'd26, 16'h0);
    put_desc(3'd6, 1'b1, 2'd3, 32'hA0, 16'd26, 16'h0);
    put_desc(3'd7, 1'b1, 2'd1, 32'h80, 16'd25, 16'h0);

    run_switch(2'd0, 16'h0010, 32'h20, 32'h40, 16'h0010, 1'b0, "R1");
    run_switch(2'd1, 16'h0018, 32'h40, 32'h60, 16'h0020, 1'b0, "R2");
    run_switch(2'd2, 16'h0000, 32'h60, 32'h40, 16'h0010, 1'b0, "R5");
    run_fault(2'd2, 16'h0000, 2'd3, "R6");
    run_fault(2'd0, 16'h0028, 2'd0, "R7");
    run_fault(2'd0, 16'h0030, 2'd1, "R7");
    run_fault(2'd0, 16'h0038, 2'd2, "R7");
    run_fault(2'd1, 16'h0000, 2'd1, "R2");
    run_switch(2'd0, 16'h0008, 32'h40, 32'h20, 16'h0008, 1'b1, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule